// File: doc/BRIEF.md
# Audio Codec Power-Up Sequencer

This block sits on the host side of an external stereo audio codec. It takes the codec from reset to running as clock master, with its internal PLL locked and its serial audio clocks present. A single start pulse runs the whole bring-up. The sequencer turns on the master clock that feeds the codec and pulses the codec's active-low power-down pin. It then issues a fixed chain of six register writes, with settling waits at the two points where the analog parts of the codec need time. Finally it confirms that the codec has begun to drive its frame clock.

Register writes are handed to a separate serial control-port master over a plain valid/ready handshake that carries an 8-bit register address and 8-bit data. Every wait is a parameter counted in system clock cycles, so the same block serves any system clock rate. When the run ends, exactly one of two sticky flags is set. One means the frame clock was seen and the codec is up. The other means it stayed silent through the detection window. A later start pulse repeats the full bring-up from the power-down pulse.

Top module: `codec_pwrup_seq`

## Requirements
- R1: After reset, `codec_pdn_n`, `mclk_en`, `wr_valid`, `done` and `err` are all 0.
- R2: A start pulse accepted while idle, done or in error sets `mclk_en` to 1 and drives `codec_pdn_n` low. `codec_pdn_n` stays low for between RST_LOW_CYC and RST_LOW_CYC+3 cycles, then goes high. No write is offered while `codec_pdn_n` is low.
- R3: Each run issues exactly six writes as (address, data) pairs, in this order: (0x00,0x00), (0x01,0x08), (0x05,0x6B), (0x06,0x0B), (0x00,0x40), (0x01,0x0C). `mclk_en` is 1 whenever `wr_valid` is 1.
- R4: Once raised, `wr_valid` stays high with `wr_addr` and `wr_data` unchanged until a cycle in which `wr_ready` is high. Each completed handshake transfers exactly one write.
- R5: After the handshake of the write of 0x40 to address 0x00, the next write is not offered for more than VREF_SETTLE_CYC cycles.
- R6: After the handshake of the write of 0x0C to address 0x01, the block waits PLL_LOCK_CYC cycles before it opens the detection window. Frame-clock edges that arrive during this wait do not count toward the detection threshold.
- R7: `done` rises when FCLK_EDGES rising edges of `fclk` are seen inside the detection window. It stays high until the next accepted start. `done` and `err` are never high together.
- R8: If fewer than FCLK_EDGES rising edges of `fclk` arrive within DETECT_WIN_CYC cycles of the window opening, `err` rises. It stays high until the next accepted start.
- R9: A start pulse that arrives while a run is in progress is ignored. `codec_pdn_n` does not fall, and the write list continues without a repeat.
- R10: A start after `done` or `err` clears both flags and repeats the whole run, beginning with a fresh power-down pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the bring-up |
| mclk_en | output | 1 | Enable for the master clock that feeds the codec |
| codec_pdn_n | output | 1 | Active-low power-down pin of the codec |
| wr_valid | output | 1 | Register write request to the control-port master |
| wr_addr | output | 8 | Register address of the pending write |
| wr_data | output | 8 | Data of the pending write |
| wr_ready | input | 1 | Control-port master accepts the pending write |
| fclk | input | 1 | Frame clock from the codec (asynchronous) |
| done | output | 1 | Bring-up finished, frame clock present |
| err | output | 1 | Frame clock not seen within the window |

## Verification
The bench stalls `wr_ready` for several cycles to catch a request that drops or changes address while it waits, or that advances to the next write before the handshake. A design that skipped a wait or counted the wrong write as the reference power-up would show a gap that is too short between the fifth and sixth writes. Frame-clock edges sent during the PLL lock wait, and a run that delivers one edge fewer than the threshold, expose a detector that is open too early or compares off by one; either fault would raise `done` where `err` is due. A start pulse in the middle of a run and starts after both outcomes catch a sequencer that restarts while busy, or that keeps a stale flag.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;

  localparam int unsigned REG_AW  = 8;
  localparam int unsigned REG_DW  = 8;
  localparam int unsigned N_WR    = 6;
  localparam int unsigned IDX_W   = $clog2(N_WR);
  localparam int unsigned IDX_REF = 4;   // reference power-up write
  localparam int unsigned IDX_PLL = 5;   // PLL enable write (last)

  typedef struct packed {
    logic [REG_AW-1:0] addr;
    logic [REG_DW-1:0] data;
  } wr_item_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST,
    ST_ISSUE,
    ST_WAITW,
    ST_SETTLE,
    ST_LOCK,
    ST_DETECT,
    ST_DONE,
    ST_ERR
  } seq_state_t;

  // Ordered bring-up script; the order is behaviour and must not change.
  function automatic wr_item_t script_item(input logic [IDX_W-1:0] idx);
    wr_item_t it;
    case (idx)
      3'd0:    it = '{addr: 8'h00, data: 8'h00};  // dummy access after reset
      3'd1:    it = '{addr: 8'h01, data: 8'h08};  // master mode selected
      3'd2:    it = '{addr: 8'h05, data: 8'h6B};  // PLL reference and rate
      3'd3:    it = '{addr: 8'h06, data: 8'h0B};  // interface format
      3'd4:    it = '{addr: 8'h00, data: 8'h40};  // reference/regulator on
      default: it = '{addr: 8'h01, data: 8'h0C};  // PLL on, master kept
    endcase
    return it;
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] len,
  output logic         expired
);

  logic [W-1:0] cnt_q;
  logic         run_q;

  // expired pulses exactly len cycles after the start edge
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (start) begin
        cnt_q <= len;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (cnt_q <= W'(1)) begin
          run_q   <= 1'b0;
          expired <= 1'b1;
        end else begin
          cnt_q <= cnt_q - W'(1);
        end
      end
    end
  end

  p_run_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q != '0));

  p_start_len_r5: assert property (@(posedge clk) disable iff (rst)
    start |-> (len != '0));

endmodule

// File: rtl/seq_wr_port.sv
module seq_wr_port
  import codec_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  wr_item_t          item,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [REG_AW-1:0] wr_addr,
  output logic [REG_DW-1:0] wr_data,
  output logic              xfer_done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      xfer_done <= 1'b0;
    end else begin
      xfer_done <= 1'b0;
      if (wr_valid) begin
        if (wr_ready) begin
          wr_valid  <= 1'b0;
          xfer_done <= 1'b1;
        end
      end else if (issue) begin
        wr_valid <= 1'b1;
        wr_addr  <= item.addr;
        wr_data  <= item.data;
      end
    end
  end

  p_hold_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  p_issue_when_free_r4: assert property (@(posedge clk) disable iff (rst)
    issue |-> !wr_valid);

  p_done_after_hs_r4: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> (!wr_valid && $past(wr_valid) && $past(wr_ready)));

endmodule

// File: rtl/seq_edge_det.sv
module seq_edge_det #(
  parameter int unsigned TARGET = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic enable,
  input  logic fclk_in,
  output logic hit
);

  localparam int unsigned CW = $clog2(TARGET + 1);

  logic [1:0]    sync_q;
  logic          prev_q;
  logic          rise;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], fclk_in};
      prev_q <= sync_q[1];
    end
  end

  assign rise = sync_q[1] & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
      hit   <= 1'b0;
    end else begin
      if (enable && rise && (cnt_q < CW'(TARGET)))
        cnt_q <= cnt_q + CW'(1);
      hit <= enable && (cnt_q == CW'(TARGET));
    end
  end

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(TARGET));

  p_idle_no_count_r6: assert property (@(posedge clk) disable iff (rst)
    (!enable && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/codec_pwrup_seq.sv
module codec_pwrup_seq
  import codec_seq_pkg::*;
#(
  parameter int unsigned RST_LOW_CYC     = 32,
  parameter int unsigned VREF_SETTLE_CYC = 250_100,
  parameter int unsigned PLL_LOCK_CYC    = 625_000,
  parameter int unsigned DETECT_WIN_CYC  = 100_000,
  parameter int unsigned FCLK_EDGES      = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output logic       mclk_en,
  output logic       codec_pdn_n,
  output logic       wr_valid,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  input  logic       wr_ready,
  input  logic       fclk,
  output logic       done,
  output logic       err
);

  localparam int unsigned MAX_A   = (RST_LOW_CYC > VREF_SETTLE_CYC) ? RST_LOW_CYC : VREF_SETTLE_CYC;
  localparam int unsigned MAX_B   = (PLL_LOCK_CYC > DETECT_WIN_CYC) ? PLL_LOCK_CYC : DETECT_WIN_CYC;
  localparam int unsigned MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned TW      = $clog2(MAX_LEN + 1);

  seq_state_t      state_q;
  logic [IDX_W-1:0] idx_q;
  logic            tmr_start_q;
  logic [TW-1:0]   tmr_len_q;
  logic            tmr_exp;
  logic            issue_q;
  logic            xfer_done;
  logic            det_clear_q;
  logic            det_en;
  logic            det_hit;
  logic            accept_start;
  wr_item_t        cur_item;

  assign cur_item     = script_item(idx_q);
  assign det_en       = (state_q == ST_DETECT);
  assign accept_start = start && ((state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_ERR));

  seq_timer #(.W(TW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start   (tmr_start_q),
    .len     (tmr_len_q),
    .expired (tmr_exp)
  );

  seq_wr_port u_wr (
    .clk       (clk),
    .rst       (rst),
    .issue     (issue_q),
    .item      (cur_item),
    .wr_ready  (wr_ready),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .xfer_done (xfer_done)
  );

  seq_edge_det #(.TARGET(FCLK_EDGES)) u_det (
    .clk     (clk),
    .rst     (rst),
    .clear   (det_clear_q),
    .enable  (det_en),
    .fclk_in (fclk),
    .hit     (det_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      tmr_start_q <= 1'b0;
      tmr_len_q   <= '0;
      issue_q     <= 1'b0;
      det_clear_q <= 1'b0;
      mclk_en     <= 1'b0;
      codec_pdn_n <= 1'b0;
      done        <= 1'b0;
      err         <= 1'b0;
    end else begin
      tmr_start_q <= 1'b0;
      issue_q     <= 1'b0;
      det_clear_q <= 1'b0;
      if (accept_start) begin
        state_q     <= ST_RST;
        idx_q       <= '0;
        mclk_en     <= 1'b1;
        codec_pdn_n <= 1'b0;
        done        <= 1'b0;
        err         <= 1'b0;
        tmr_start_q <= 1'b1;
        tmr_len_q   <= TW'(RST_LOW_CYC);
      end else begin
        unique case (state_q)
          ST_RST: if (tmr_exp) begin
            codec_pdn_n <= 1'b1;
            state_q     <= ST_ISSUE;
          end
          ST_ISSUE: begin
            issue_q <= 1'b1;
            state_q <= ST_WAITW;
          end
          ST_WAITW: if (xfer_done) begin
            if (idx_q == IDX_W'(IDX_PLL)) begin
              state_q     <= ST_LOCK;
              tmr_start_q <= 1'b1;
              tmr_len_q   <= TW'(PLL_LOCK_CYC);
            end else begin
              idx_q <= idx_q + IDX_W'(1);
              if (idx_q == IDX_W'(IDX_REF)) begin
                state_q     <= ST_SETTLE;
                tmr_start_q <= 1'b1;
                tmr_len_q   <= TW'(VREF_SETTLE_CYC);
              end else begin
                state_q <= ST_ISSUE;
              end
            end
          end
          ST_SETTLE: if (tmr_exp) state_q <= ST_ISSUE;
          ST_LOCK: if (tmr_exp) begin
            state_q     <= ST_DETECT;
            det_clear_q <= 1'b1;
            tmr_start_q <= 1'b1;
            tmr_len_q   <= TW'(DETECT_WIN_CYC);
          end
          ST_DETECT: begin
            if (det_hit) begin
              state_q <= ST_DONE;
              done    <= 1'b1;
            end else if (tmr_exp) begin
              state_q <= ST_ERR;
              err     <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_flags_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(done && err));

  p_no_write_in_pdn_r2: assert property (@(posedge clk) disable iff (rst)
    !codec_pdn_n |-> !wr_valid);

  p_mclk_on_write_r3: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> mclk_en);

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (err && !start) |=> err);

  p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (start && codec_pdn_n && !done && !err && (state_q != ST_IDLE)) |=> codec_pdn_n);

  p_restart_clears_r10: assert property (@(posedge clk) disable iff (rst)
    ((done || err) && start) |=> (!done && !err && !codec_pdn_n));

endmodule

// File: tb/codec_pwrup_seq_tb_top.sv
module codec_pwrup_seq_tb_top;

  localparam int RST_L  = 4;
  localparam int SETTLE = 20;
  localparam int LOCK   = 30;
  localparam int WIN    = 40;
  localparam int EDGES  = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst, start, wr_ready, fclk;
  logic       mclk_en, codec_pdn_n, wr_valid, done, err;
  logic [7:0] wr_addr, wr_data;

  codec_pwrup_seq #(
    .RST_LOW_CYC(RST_L), .VREF_SETTLE_CYC(SETTLE), .PLL_LOCK_CYC(LOCK),
    .DETECT_WIN_CYC(WIN), .FCLK_EDGES(EDGES)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start), .mclk_en(mclk_en), .codec_pdn_n(codec_pdn_n),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
    .fclk(fclk), .done(done), .err(err)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  int         n_wr;
  logic [7:0] la [0:15];
  logic [7:0] ld [0:15];
  int         lc [0:15];
  int         pdn_low_cnt, pdn_falls, pdn_rise_cyc;
  int         rdy_delay, wait_cnt;
  bit         hold_err, stall_prev;
  logic [7:0] pa, pd;
  logic       prev_pdn;

  function automatic logic [7:0] exp_addr(input int i);
    case (i) 0: return 8'h00; 1: return 8'h01; 2: return 8'h05;
             3: return 8'h06; 4: return 8'h00; default: return 8'h01; endcase
  endfunction
  function automatic logic [7:0] exp_data(input int i);
    case (i) 0: return 8'h00; 1: return 8'h08; 2: return 8'h6B;
             3: return 8'h0B; 4: return 8'h40; default: return 8'h0C; endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // control-port responder and monitor, all at the falling edge
  task automatic port_model();
    forever begin
      @(negedge clk);
      cyc++;
      if (!codec_pdn_n) pdn_low_cnt++;
      if (prev_pdn && !codec_pdn_n) pdn_falls++;
      if (!prev_pdn && codec_pdn_n) pdn_rise_cyc = cyc;
      prev_pdn = codec_pdn_n;
      if (stall_prev && (!wr_valid || wr_addr != pa || wr_data != pd)) hold_err = 1'b1;
      stall_prev = 1'b0;
      if (wr_ready) begin
        wr_ready = 1'b0;
      end else if (wr_valid) begin
        if (wait_cnt >= rdy_delay) begin
          if (n_wr < 16) begin
            la[n_wr] = wr_addr; ld[n_wr] = wr_data; lc[n_wr] = cyc;
          end
          n_wr++;
          wr_ready = 1'b1;
          wait_cnt = 0;
        end else begin
          wait_cnt++;
          stall_prev = 1'b1;
          pa = wr_addr; pd = wr_data;
        end
      end
    end
  endtask

  task automatic clear_mon(input int delay);
    @(negedge clk); #1;
    n_wr = 0; pdn_low_cnt = 0; pdn_falls = 0; pdn_rise_cyc = 0;
    hold_err = 1'b0; rdy_delay = delay; wait_cnt = 0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_writes(input int n, input string req);
    int t = 0;
    while (n_wr < n && t < 2000) begin @(negedge clk); t++; end
    #1;
    chk(n_wr >= n, req, "writes seen", n_wr, n);
  endtask

  task automatic gen_edges(input int n, input int half);
    for (int i = 0; i < n; i++) begin
      fclk = 1'b1; repeat (half) @(negedge clk);
      fclk = 1'b0; repeat (half) @(negedge clk);
    end
  endtask

  task automatic check_order(input string req);
    for (int i = 0; i < 6; i++) begin
      chk(la[i] == exp_addr(i), req, $sformatf("addr of write %0d", i), la[i], exp_addr(i));
      chk(ld[i] == exp_data(i), req, $sformatf("data of write %0d", i), ld[i], exp_data(i));
    end
  endtask

  task automatic t_reset_state();
    @(negedge clk); #1;
    chk(codec_pdn_n == 0, "R1", "pdn_n", codec_pdn_n, 0);
    chk(mclk_en == 0, "R1", "mclk_en", mclk_en, 0);
    chk(wr_valid == 0, "R1", "wr_valid", wr_valid, 0);
    chk(done == 0 && err == 0, "R1", "done|err", done | err, 0);
  endtask

  task automatic t_bringup_done();
    clear_mon(0);
    pulse_start();
    chk(mclk_en == 1, "R2", "mclk_en after start", mclk_en, 1);
    chk(codec_pdn_n == 0, "R2", "pdn_n after start", codec_pdn_n, 0);
    wait_writes(6, "R3");
    check_order("R3");
    chk(pdn_low_cnt >= RST_L && pdn_low_cnt <= RST_L + 3, "R2", "pdn low cycles", pdn_low_cnt, RST_L);
    chk(lc[0] > pdn_rise_cyc, "R2", "first write after pdn rise", lc[0], pdn_rise_cyc + 1);
    chk(lc[5] - lc[4] > SETTLE, "R5", "settle gap", lc[5] - lc[4], SETTLE + 1);
    repeat (LOCK + 10) @(negedge clk);
    gen_edges(EDGES, 2);
    repeat (WIN) @(negedge clk); #1;
    chk(done == 1 && err == 0, "R7", "done after edges", done, 1);
    repeat (20) @(negedge clk); #1;
    chk(done == 1, "R7", "done stays high", done, 1);
    chk(n_wr == 6, "R3", "write count", n_wr, 6);
  endtask

  task automatic t_restart_timeout();
    clear_mon(3);
    pulse_start();
    chk(done == 0 && err == 0, "R10", "flags cleared on restart", done | err, 0);
    chk(codec_pdn_n == 0, "R10", "pdn_n low on restart", codec_pdn_n, 0);
    wait_writes(6, "R10");
    check_order("R10");
    chk(hold_err == 0, "R4", "valid/addr/data held during stall", hold_err, 0);
    repeat (LOCK + WIN + 20) @(negedge clk); #1;
    chk(err == 1 && done == 0, "R8", "err after silent window", err, 1);
  endtask

  task automatic t_lock_edges_ignored();
    clear_mon(1);
    pulse_start();
    chk(err == 0 && codec_pdn_n == 0, "R10", "restart after err", err, 0);
    wait_writes(6, "R6");
    repeat (2) @(negedge clk);
    gen_edges(EDGES + 1, 2);
    repeat (LOCK + WIN + 20) @(negedge clk); #1;
    chk(err == 1 && done == 0, "R6", "edges in lock wait ignored", done, 0);
  endtask

  task automatic t_short_edges();
    clear_mon(0);
    pulse_start();
    wait_writes(6, "R8");
    repeat (LOCK + 10) @(negedge clk);
    gen_edges(EDGES - 1, 2);
    repeat (WIN + 10) @(negedge clk); #1;
    chk(err == 1 && done == 0, "R8", "one edge short gives err", err, 1);
  endtask

  task automatic t_busy_start();
    clear_mon(2);
    pulse_start();
    wait_writes(5, "R9");
    repeat (3) @(negedge clk);
    pulse_start();
    #1;
    chk(codec_pdn_n == 1, "R9", "pdn_n after busy start", codec_pdn_n, 1);
    wait_writes(6, "R9");
    check_order("R9");
    repeat (LOCK + 10) @(negedge clk);
    gen_edges(EDGES, 3);
    repeat (WIN) @(negedge clk); #1;
    chk(n_wr == 6, "R9", "no repeated writes", n_wr, 6);
    chk(pdn_falls == 1, "R9", "pdn falls in run", pdn_falls, 1);
    chk(done == 1 && err == 0, "R9", "run completes", done, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; wr_ready = 1'b0; fclk = 1'b0;
    prev_pdn = 1'b0; stall_prev = 1'b0; rdy_delay = 0; wait_cnt = 0;
    n_wr = 0; hold_err = 1'b0; pdn_low_cnt = 0; pdn_falls = 0; pdn_rise_cyc = 0;
    fork port_model(); join_none
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_bringup_done();
    t_restart_timeout();
    t_lock_edges_ignored();
    t_short_edges();
    t_busy_start();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule